// File: doc/BRIEF.md
# Program/Erase Status Bit Generator

This block builds the word a flash device returns on a read while an internal program or erase is running, or while an erase is on hold. A small state machine follows the write operation. Command pulses from the sequencer start it, the array timer ends it, and suspend and resume requests move it into and out of a hold. On each read strobe the block captures either the plain array word or the array word with status bits laid over it. A one-cycle `rd_valid` pulse comes with the captured word.

Two toggle flip-flops advance on read strobes, not on the clock. The bit-6 toggle flips on every read taken while a program or erase is active. The bit-2 toggle flips only on erase-type reads. Comparing two reads therefore tells software whether anything is active, and whether a given sector is erasing or on hold as opposed to being programmed. The data-polling bit 7 shows the inverse of the bit being written during a program. It shows 0 during an erase. It shows 1 for reads inside a region whose erase is on hold.

States: `ST_IDLE`, `ST_PROG`, `ST_ERASE`, `ST_SUSP`, `ST_SUSP_PROG`. Transitions:
- `ST_IDLE` goes to `ST_PROG` on `start_prog`, or to `ST_ERASE` on `start_erase`.
- `ST_PROG` goes to `ST_IDLE` on `op_done`.
- `ST_ERASE` goes to `ST_IDLE` on `op_done`, or to `ST_SUSP` on `erase_suspend`.
- `ST_SUSP` goes to `ST_ERASE` on `erase_resume`, or to `ST_SUSP_PROG` on `start_prog` when the address is outside the held region.
- `ST_SUSP_PROG` goes back to `ST_SUSP` on `op_done`.

Top module: `pe_status_gen`

## Requirements
- R1: After reset, `rd_valid` and `rd_data` are 0, the machine is in `ST_IDLE`, and both toggles are 0.
- R2: A read strobe in cycle n gives `rd_valid` = 1 and the captured word in cycle n+1. In `ST_IDLE` that word equals `arr_data`.
- R3: In a program (`ST_PROG` or `ST_SUSP_PROG`), bit 7 of a read is the inverse of the `wr_d7` value captured with `start_prog`. Bit 6 is the bit-6 toggle. All other bits come from `arr_data`.
- R4: In `ST_ERASE`, a read has bit 7 = 0, bit 6 = the bit-6 toggle and bit 2 = the bit-2 toggle. The other bits come from `arr_data`.
- R5: The bit-6 toggle inverts on every read strobe taken in `ST_PROG`, `ST_ERASE` or `ST_SUSP_PROG`, and holds otherwise. A read shows the value from before its own flip.
- R6: During a program, bit 2 is not a toggle: the bit-2 toggle holds, and bit 2 of the read equals `arr_data[2]`.
- R7: `op_done` ends an operation. After it, reads in `ST_IDLE` return the array word unmodified, so bit 7 is the true stored bit.
- R8: In `ST_SUSP`, a read with `addr_in_susp` = 1 has bit 7 = 1, bit 6 = 1 and bit 2 = the bit-2 toggle, and that read inverts the bit-2 toggle.
- R9: In `ST_SUSP`, a read with `addr_in_susp` = 0 returns `arr_data` unchanged and advances neither toggle.
- R10: In `ST_SUSP`, `start_prog` with `addr_in_susp` = 0 enters `ST_SUSP_PROG`. `op_done` there returns to `ST_SUSP`.
- R11: In `ST_SUSP`, `start_prog` with `addr_in_susp` = 1 is ignored. Later reads inside the held region still show bits 7:6 = 11.
- R12: `start_prog` and `start_erase` are ignored while a program or erase is active. `erase_resume` returns `ST_SUSP` to `ST_ERASE`.
- R13: In `ST_ERASE`, `op_done` takes priority over `erase_suspend` when both arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_prog | input | 1 | Pulse: last write of a program sequence accepted |
| start_erase | input | 1 | Pulse: last write of an erase sequence accepted |
| erase_suspend | input | 1 | Pulse: hold the running erase |
| erase_resume | input | 1 | Pulse: continue the held erase |
| op_done | input | 1 | Pulse from the array timer: current operation finished |
| wr_d7 | input | 1 | Bit 7 of the word being programmed, captured with start_prog |
| addr_in_susp | input | 1 | Current address lies in the erase-held sector or block |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| arr_data | input | DW | Array word at the read address |
| rd_data | output | DW | Captured read word |
| rd_valid | output | 1 | rd_data was captured by the previous cycle's strobe |

## Verification
The bench takes back-to-back reads in every state. A design that advanced a toggle on the clock, or that showed the post-flip value, would break the expected alternation. Bit 2 is followed through a program: a design that let it toggle there would lose the erase/program distinction. Suspend is probed inside and outside the held region, including a program attempt inside it, which a careless design would start. Two more cases cover commands issued during an active operation and a completion that coincides with a suspend request; mishandling either would leave the machine in the wrong state and corrupt later reads.

// File: rtl/pesg_pkg.sv
package pesg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_SUSP_PROG
    } pesg_state_e;

    localparam int BIT_POLL = 7;
    localparam int BIT_TGL  = 6;
    localparam int BIT_ETGL = 2;
endpackage

// File: rtl/pesg_fsm.sv
module pesg_fsm
    import pesg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_prog,
    input  logic        start_erase,
    input  logic        erase_suspend,
    input  logic        erase_resume,
    input  logic        op_done,
    input  logic        addr_in_susp,
    input  logic        wr_d7,
    output pesg_state_e state,
    output logic        prog_d7
);
    pesg_state_e state_nx;
    logic        prog_launch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_prog)       state_nx = ST_PROG;
                else if (start_erase) state_nx = ST_ERASE;
            end
            ST_PROG: begin
                if (op_done) state_nx = ST_IDLE;
            end
            ST_ERASE: begin
                if (op_done)            state_nx = ST_IDLE;
                else if (erase_suspend) state_nx = ST_SUSP;
            end
            ST_SUSP: begin
                if (erase_resume)                      state_nx = ST_ERASE;
                else if (start_prog && !addr_in_susp)  state_nx = ST_SUSP_PROG;
            end
            ST_SUSP_PROG: begin
                if (op_done) state_nx = ST_SUSP;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign prog_launch = (state_nx == ST_PROG && state == ST_IDLE) ||
                         (state_nx == ST_SUSP_PROG && state == ST_SUSP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           prog_d7 <= 1'b0;
        else if (prog_launch) prog_d7 <= wr_d7;
    end

    // R13: completion wins over a same-cycle suspend request
    a_r13_done_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && op_done) |=> state == ST_IDLE);
    // R11: program into the held region is refused
    a_r11_no_prog_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && start_prog && addr_in_susp && !erase_resume) |=> state == ST_SUSP);
endmodule

// File: rtl/pesg_toggle.sv
module pesg_toggle
    import pesg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_stb,
    input  pesg_state_e state,
    input  logic        addr_in_susp,
    output logic        tgl6,
    output logic        tgl2
);
    logic adv6, adv2;

    always_comb begin
        adv6 = 1'b0;
        adv2 = 1'b0;
        unique case (state)
            ST_PROG, ST_SUSP_PROG: adv6 = rd_stb;
            ST_ERASE: begin
                adv6 = rd_stb;
                adv2 = rd_stb;
            end
            ST_SUSP: adv2 = rd_stb && addr_in_susp;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl6 <= 1'b0;
            tgl2 <= 1'b0;
        end else begin
            if (adv6) tgl6 <= ~tgl6;
            if (adv2) tgl2 <= ~tgl2;
        end
    end

    // R5: every read taken during an active operation flips bit 6
    a_r5_tgl6_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (state == ST_PROG || state == ST_ERASE)) |=> tgl6 != $past(tgl6));
    // R6: bit-2 toggle holds through a program
    a_r6_tgl2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG || state == ST_SUSP_PROG) |=> $stable(tgl2));
endmodule

// File: rtl/pesg_word.sv
module pesg_word
    import pesg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  pesg_state_e   state,
    input  logic          addr_in_susp,
    input  logic [DW-1:0] arr_data,
    input  logic          prog_d7,
    input  logic          tgl6,
    input  logic          tgl2,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [DW-1:0] word_nx;

    always_comb begin
        word_nx = arr_data;
        unique case (state)
            ST_PROG, ST_SUSP_PROG: begin
                word_nx[BIT_POLL] = ~prog_d7;
                word_nx[BIT_TGL]  = tgl6;
            end
            ST_ERASE: begin
                word_nx[BIT_POLL] = 1'b0;
                word_nx[BIT_TGL]  = tgl6;
                word_nx[BIT_ETGL] = tgl2;
            end
            ST_SUSP: begin
                if (addr_in_susp) begin
                    word_nx[BIT_POLL] = 1'b1;
                    word_nx[BIT_TGL]  = 1'b1;
                    word_nx[BIT_ETGL] = tgl2;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= word_nx;
        end
    end
endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
    import pesg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_prog,
    input  logic          start_erase,
    input  logic          erase_suspend,
    input  logic          erase_resume,
    input  logic          op_done,
    input  logic          wr_d7,
    input  logic          addr_in_susp,
    input  logic          rd_stb,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    pesg_state_e state;
    logic        prog_d7;
    logic        tgl6, tgl2;

    pesg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_prog(start_prog), .start_erase(start_erase),
        .erase_suspend(erase_suspend), .erase_resume(erase_resume),
        .op_done(op_done), .addr_in_susp(addr_in_susp), .wr_d7(wr_d7),
        .state(state), .prog_d7(prog_d7)
    );

    pesg_toggle u_tgl (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .state(state),
        .addr_in_susp(addr_in_susp), .tgl6(tgl6), .tgl2(tgl2)
    );

    pesg_word #(.DW(DW)) u_word (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .state(state),
        .addr_in_susp(addr_in_susp), .arr_data(arr_data), .prog_d7(prog_d7),
        .tgl6(tgl6), .tgl2(tgl2), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // R2: one valid pulse per strobe, one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == $past(rd_stb));
    // R3: inverted polling bit during a program
    a_r3_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && state == ST_PROG) |=> rd_data[BIT_POLL] == ~$past(prog_d7));
    // R4: polling bit low while erasing
    a_r4_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && state == ST_ERASE) |=> rd_data[BIT_POLL] == 1'b0);
    // R8: held region reads high on bits 7 and 6
    a_r8_hold_region: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && state == ST_SUSP && addr_in_susp) |=> rd_data[BIT_POLL:BIT_TGL] == 2'b11);
endmodule

// File: tb/pe_status_gen_tb.sv
module pe_status_gen_tb;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_prog = 0, start_erase = 0, erase_suspend = 0;
    logic          erase_resume = 0, op_done = 0, wr_d7 = 0, addr_in_susp = 0;
    logic          rd_stb = 0;
    logic [DW-1:0] arr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pe_status_gen #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
        .erase_suspend(erase_suspend), .erase_resume(erase_resume), .op_done(op_done),
        .wr_d7(wr_d7), .addr_in_susp(addr_in_susp), .rd_stb(rd_stb),
        .arr_data(arr_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // model: 0 idle, 1 prog, 2 erase, 3 hold, 4 prog in hold
    int   mst = 0;
    logic m7 = 0, mt6 = 0, mt2 = 0;

    typedef struct { logic [DW-1:0] w; string req; } exp_t;
    exp_t q[$];

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [DW-1:0] arr, input bit ins, input string req);
        exp_t e;
        e.w = arr;
        e.req = req;
        case (mst)
            1, 4: begin e.w[7] = ~m7; e.w[6] = mt6; mt6 = ~mt6; end
            2: begin e.w[7] = 1'b0; e.w[6] = mt6; e.w[2] = mt2; mt6 = ~mt6; mt2 = ~mt2; end
            3: if (ins) begin e.w[7] = 1'b1; e.w[6] = 1'b1; e.w[2] = mt2; mt2 = ~mt2; end
            default: ;
        endcase
        q.push_back(e);
        @(posedge clk); #1;
        rd_stb = 1; arr_data = arr; addr_in_susp = ins;
        @(posedge clk); #1;
        rd_stb = 0;
    endtask

    // kind: 0 prog, 1 erase, 2 suspend, 3 resume, 4 done, 5 done+suspend
    task automatic cmd(input int kind, input bit ins, input logic d7);
        @(posedge clk); #1;
        addr_in_susp = ins; wr_d7 = d7;
        case (kind)
            0: begin start_prog = 1;
                if (mst == 0) begin mst = 1; m7 = d7; end
                else if (mst == 3 && !ins) begin mst = 4; m7 = d7; end end
            1: begin start_erase = 1; if (mst == 0) mst = 2; end
            2: begin erase_suspend = 1; if (mst == 2) mst = 3; end
            3: begin erase_resume = 1; if (mst == 3) mst = 2; end
            4: begin op_done = 1;
                if (mst == 1 || mst == 2) mst = 0; else if (mst == 4) mst = 3; end
            default: begin op_done = 1; erase_suspend = 1; if (mst == 2) mst = 0; end
        endcase
        @(posedge clk); #1;
        start_prog = 0; start_erase = 0; erase_suspend = 0;
        erase_resume = 0; op_done = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            exp_t e;
            if (q.size() == 0) chk(0, "R2 unexpected valid", rd_data, '0);
            else begin
                e = q.pop_front();
                chk(rd_data === e.w, e.req, rd_data, e.w);
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            chk(0, "watchdog", '0, '0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(rd_valid === 1'b0, "R1 valid low", {15'd0, rd_valid}, '0);
        chk(rd_data === '0, "R1 data zero", rd_data, '0);
        rst_n = 1;
        rd(16'hA5C3, 0, "R2 idle read");
        rd(16'h0F0F, 1, "R2 idle read region flag");
        cmd(0, 0, 1'b1);
        rd(16'h1234, 0, "R3 R5 prog read 1");
        rd(16'h1234, 0, "R5 R6 prog read 2");
        rd(16'h1234, 0, "R5 R6 prog read 3");
        cmd(1, 0, 1'b0);
        rd(16'h0004, 0, "R12 erase ignored in prog");
        cmd(4, 0, 1'b0);
        rd(16'h80FF, 0, "R7 true data after done");
        cmd(1, 0, 1'b0);
        rd(16'hFFFF, 0, "R4 erase read 1");
        rd(16'hFFFF, 0, "R4 erase read 2");
        rd(16'h0000, 0, "R4 erase read 3");
        cmd(0, 0, 1'b0);
        rd(16'hFFFF, 0, "R12 prog ignored in erase");
        cmd(2, 0, 1'b0);
        rd(16'h0000, 1, "R8 hold region read 1");
        rd(16'h0000, 1, "R8 hold region read 2");
        rd(16'h3C3C, 0, "R9 outside hold read");
        rd(16'h0000, 1, "R9 toggle untouched by outside read");
        cmd(0, 1, 1'b0);
        rd(16'h0000, 1, "R11 prog in held region ignored");
        cmd(0, 0, 1'b0);
        rd(16'h0044, 0, "R10 R3 prog in hold read 1");
        rd(16'h0044, 0, "R10 prog in hold read 2");
        cmd(4, 0, 1'b0);
        rd(16'h0000, 1, "R10 back to hold");
        cmd(3, 0, 1'b0);
        rd(16'hAAAA, 0, "R12 resume erase status");
        cmd(5, 0, 1'b0);
        rd(16'h5555, 0, "R13 done beats suspend");
        repeat (4) @(posedge clk);
        chk(q.size() == 0, "R2 all reads returned", DW'(q.size()), '0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule